// File: doc/BRIEF.md
# Printer-Port to SRAM Bridge

This block lets a host that owns only an 8-bit latched output byte, a 4-bit latched control register and a few status inputs read and write an SRAM port with an 11-bit address and 8-bit data. The host places a byte on its output lines, then flips one control bit away from its quiet value and back. That pulses exactly one strobe, and the strobe captures the byte into one of three internal registers:
- the memory-control byte, which also carries the high address bits;
- the low address byte;
- the write-data byte.

Read data returns as two 4-bit nibbles on the status lines. A control bit picks which nibble is shown. The host merges the two as high×16 + low.

All captures are synchronous to `clk`. A register loads on the first clock edge at which its decoded strobe line is seen high after being low. The host side has no data stream and no back-pressure: each byte is framed by a strobe, and the host's own pacing is the only flow control. The memory side uses separate write-data and read-data buses plus a drive-enable, instead of a shared tri-state bus.

Top module: `ppsb_bridge`

## Requirements
- R1: After reset the bridge holds the memory idle. `mem_ce_n`=1, `mem_oe_n`=1, `mem_rw`=1 (read) and `mem_wdata_oe`=0. `mem_addr` and `mem_wdata` are 0.
- R2: Control bit 2 reaches its strobe line with unchanged polarity. Bits 0, 1 and 3 are inverted. The quiet value 4'hB leaves every line low, so any stay at the quiet value, with any `host_data`, changes nothing.
- R3: A rising strobe on line 2 (value 4'hF after quiet) captures `host_data` into the control register. Bits [2:0] become `mem_addr[10:8]`, bit 4 drives `mem_oe_n`, bit 5 drives `mem_rw` (1 = read, 0 = write), bit 6 = 1 turns the data driver off, and bit 7 drives `mem_ce_n`.
- R4: A rising strobe on line 0 (value 4'hA) captures `host_data` into `mem_addr[7:0]`.
- R5: A rising strobe on line 3 (value 4'h3) captures `host_data` into `mem_wdata`.
- R6: Each strobe captures exactly once per assertion. Holding the alternate value while `host_data` changes does not recapture, and no two registers load in the same cycle.
- R7: `mem_wdata_oe` is high exactly when control bit 6 is 0, so the driver floats for reads (arm byte 0x70) and drives for writes (0x20).
- R8: With control bit 1 set (quiet), the status lines carry `mem_rdata[3:0]`. With bit 1 clear (4'h9), they carry `mem_rdata[7:4]`.
- R9: Status line 3 reaches the host through an inverting busy input, so the bridge drives that line pre-inverted and the host reads the true bit.
- R10: The byte sequences arm-read 0x70, issue-read 0x60, arm-write 0x20 and commit-write 0x00, each combined with the high address bits, write any byte to any address and read it back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_data | input | 8 | Host latched output byte |
| host_ctrl | input | 4 | Host control register bits, before line polarity |
| host_status | output | 4 | Nibble to host status lines, line 3 pre-inverted |
| mem_addr | output | 11 | SRAM address |
| mem_ce_n | output | 1 | SRAM chip enable, active low |
| mem_rw | output | 1 | SRAM read (1) / write (0) |
| mem_oe_n | output | 1 | SRAM output enable, active low |
| mem_wdata | output | 8 | Write data to SRAM |
| mem_wdata_oe | output | 1 | Write-data driver enable |
| mem_rdata | input | 8 | Read data from SRAM |

## Verification
The assertions check on every cycle that strobes are single-cycle and mutually exclusive, that each capture puts the byte present at its edge into the matching memory-side field, that registers hold when no strobe fires, and that a steady quiet control value never loads anything. Only the bench's scenarios can show these:
- that the host's real byte sequences write and read the SRAM correctly;
- that the nibbles reassemble in the right order;
- that the inverted busy line reads true once it passes through the host's inversion.

// File: rtl/ppsb_pkg.sv
package ppsb_pkg;
  // strobe line indices (order decoded by the latch bank)
  localparam int STB_LO  = 0;
  localparam int STB_NIB = 1;
  localparam int STB_CTL = 2;
  localparam int STB_DAT = 3;
  localparam int NUM_STB = 4;

  // control register bits whose line is inverted on the way out
  localparam logic [NUM_STB-1:0] STROBE_INV_MASK = 4'b1011;
  localparam logic [NUM_STB-1:0] CTRL_QUIET      = 4'hB;

  // control byte field positions
  localparam int CB_OE_N    = 4;
  localparam int CB_RW      = 5;
  localparam int CB_DRV_OFF = 6;
  localparam int CB_CE_N    = 7;

  // status line 3 is inverted by the host's input
  localparam logic [3:0] STAT_INV_MASK = 4'b1000;
endpackage

// File: rtl/ppsb_strobe_decode.sv
module ppsb_strobe_decode
  import ppsb_pkg::*;
#(
  parameter int N = NUM_STB,
  parameter logic [N-1:0] INV_MASK = STROBE_INV_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ctrl_bits,
  output logic [N-1:0] line_lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    assign line_lvl[i] = ctrl_bits[i] ^ INV_MASK[i];
    assign rise[i]     = line_lvl[i] & ~prev_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= line_lvl[i];
    end

    // R6: a strobe pulse never lasts two cycles while the line stays high
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> !rise[i]);
  end
endmodule

// File: rtl/ppsb_latch_bank.sv
module ppsb_latch_bank
  import ppsb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HI_W   = 3,
  localparam int CTL_W = HI_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ctl,
  input  logic              load_lo,
  input  logic              load_dat,
  input  logic [DATA_W-1:0] din,
  output logic [CTL_W-1:0]  ctl_q,   // {ce_n, drv_off, rw, oe_n, hi_addr}
  output logic [DATA_W-1:0] lo_q,
  output logic [DATA_W-1:0] dat_q
);
  localparam logic [CTL_W-1:0] CTL_RESET = {4'b1111, {HI_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET;
      lo_q  <= '0;
      dat_q <= '0;
    end else begin
      if (load_ctl) ctl_q <= {din[CB_CE_N:CB_OE_N], din[HI_W-1:0]};
      if (load_lo)  lo_q  <= din;
      if (load_dat) dat_q <= din;
    end
  end

  // R3/R4/R5: registers only change on their own strobe
  a_r3_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ctl |=> $stable(ctl_q));
  a_r4_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_lo |=> $stable(lo_q));
  a_r5_dat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_dat |=> $stable(dat_q));
endmodule

// File: rtl/ppsb_nibble_mux.sv
module ppsb_nibble_mux
  import ppsb_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int NIB_W = DATA_W / 2
) (
  input  logic              sel_hi,
  input  logic [DATA_W-1:0] rdata,
  output logic [NIB_W-1:0]  status_pins
);
  logic [NIB_W-1:0] nib;

  always_comb begin
    nib         = sel_hi ? rdata[DATA_W-1:NIB_W] : rdata[NIB_W-1:0];
    status_pins = nib ^ STAT_INV_MASK[NIB_W-1:0];
  end
endmodule

// File: rtl/ppsb_bridge.sv
module ppsb_bridge
  import ppsb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W,
  localparam int NIB_W = DATA_W / 2,
  localparam int CTL_W = HI_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] host_data,
  input  logic [3:0]        host_ctrl,
  output logic [NIB_W-1:0]  host_status,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_rw,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wdata_oe,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [NUM_STB-1:0] line_lvl;
  logic [NUM_STB-1:0] rise;
  logic [CTL_W-1:0]   ctl_q;
  logic [DATA_W-1:0]  lo_q;
  logic [DATA_W-1:0]  dat_q;

  ppsb_strobe_decode #(.N(NUM_STB), .INV_MASK(STROBE_INV_MASK)) dec_i (
    .clk(clk), .rst_n(rst_n), .ctrl_bits(host_ctrl),
    .line_lvl(line_lvl), .rise(rise));

  ppsb_latch_bank #(.DATA_W(DATA_W), .HI_W(HI_W)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .load_ctl(rise[STB_CTL]), .load_lo(rise[STB_LO]), .load_dat(rise[STB_DAT]),
    .din(host_data), .ctl_q(ctl_q), .lo_q(lo_q), .dat_q(dat_q));

  ppsb_nibble_mux #(.DATA_W(DATA_W)) mux_i (
    .sel_hi(line_lvl[STB_NIB]), .rdata(mem_rdata), .status_pins(host_status));

  always_comb begin
    mem_addr     = {ctl_q[HI_W-1:0], lo_q};
    mem_oe_n     = ctl_q[HI_W + 0];
    mem_rw       = ctl_q[HI_W + 1];
    mem_wdata_oe = ~ctl_q[HI_W + 2];
    mem_ce_n     = ctl_q[HI_W + 3];
    mem_wdata    = dat_q;
  end

  // R6: strobes are mutually exclusive
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rise));
  // R2: a steady quiet control value loads nothing
  a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ctrl == CTRL_QUIET && $past(host_ctrl) == CTRL_QUIET) |-> (rise == '0));
  // R3: control capture lands on the memory-side pins
  a_r3_ctl_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rise[STB_CTL] |=> (mem_ce_n == $past(host_data[CB_CE_N]) &&
                       mem_rw   == $past(host_data[CB_RW]) &&
                       mem_oe_n == $past(host_data[CB_OE_N]) &&
                       mem_wdata_oe == !$past(host_data[CB_DRV_OFF]) &&
                       mem_addr[ADDR_W-1:DATA_W] == $past(host_data[HI_W-1:0])));
  // R4: low address capture
  a_r4_lo_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rise[STB_LO] |=> mem_addr[DATA_W-1:0] == $past(host_data));
  // R5: write data capture
  a_r5_dat_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rise[STB_DAT] |=> mem_wdata == $past(host_data));
  // R8: quiet nibble select shows the low nibble (line 3 pre-inverted, R9)
  a_r8_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    host_ctrl[STB_NIB] |-> (host_status ^ STAT_INV_MASK[NIB_W-1:0]) == mem_rdata[NIB_W-1:0]);
endmodule

// File: tb/ppsb_bridge_tb.sv
module ppsb_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_data = 8'h00;
  logic [3:0]  host_ctrl = 4'hB;
  logic [3:0]  host_status;
  logic [10:0] mem_addr;
  logic        mem_ce_n, mem_rw, mem_oe_n, mem_wdata_oe;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  sram [2048];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  ppsb_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .host_data(host_data), .host_ctrl(host_ctrl),
    .host_status(host_status), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_rw(mem_rw), .mem_oe_n(mem_oe_n), .mem_wdata(mem_wdata),
    .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata));

  // behavioural SRAM
  assign mem_rdata = (!mem_ce_n && !mem_oe_n && mem_rw) ? sram[mem_addr] : 8'hFF;
  always @(posedge clk)
    if (!mem_ce_n && !mem_rw && mem_wdata_oe) sram[mem_addr] <= mem_wdata;

  // {addr, data} pairs
  localparam logic [18:0] VEC [0:5] = '{
    {11'h000, 8'h3C}, {11'h7FF, 8'hC3}, {11'h155, 8'hA5},
    {11'h2AA, 8'h5A}, {11'h400, 8'hFF}, {11'h0FF, 8'h00}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put_ctrl(logic [3:0] v);
    @(negedge clk) host_ctrl = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic put_data(logic [7:0] v);
    @(negedge clk) host_data = v;
  endtask

  // host view of the status lines after its inverting busy input
  function automatic logic [3:0] host_view();
    return host_status ^ 4'b1000;
  endfunction

  task automatic host_write(logic [10:0] a, logic [7:0] d);
    put_data(8'h20 | {5'd0, a[10:8]}); put_ctrl(4'hF); put_ctrl(4'hB);
    put_data(a[7:0]);                  put_ctrl(4'hA); put_ctrl(4'hB);
    put_data(d);                       put_ctrl(4'h3); put_ctrl(4'hB);
    put_data(8'h00 | {5'd0, a[10:8]}); put_ctrl(4'hF); put_ctrl(4'hB);
  endtask

  task automatic host_read(logic [10:0] a, output logic [7:0] d);
    logic [3:0] lo, hi;
    put_data(8'h70 | {5'd0, a[10:8]}); put_ctrl(4'hF); put_ctrl(4'hB);
    put_data(a[7:0]);                  put_ctrl(4'hA); put_ctrl(4'hB);
    put_data(8'h60 | {5'd0, a[10:8]}); put_ctrl(4'hF); put_ctrl(4'hB);
    lo = host_view();
    put_ctrl(4'h9);
    hi = host_view();
    put_ctrl(4'hB);
    d = {hi, lo};
  endtask

  initial begin
    logic [7:0] rd;
    logic [10:0] sa;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ce_n", mem_ce_n, 1); chk("R1 oe_n", mem_oe_n, 1);
    chk("R1 rw", mem_rw, 1);     chk("R1 drv", mem_wdata_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 addr", mem_addr, 0); chk("R1 wdata", mem_wdata, 0);

    // R10: table of writes, then reads
    for (int i = 0; i < 6; i++) host_write(VEC[i][18:8], VEC[i][7:0]);
    for (int i = 0; i < 6; i++) begin
      host_read(VEC[i][18:8], rd);
      chk("R10 readback", rd, VEC[i][7:0]);
    end

    // R3: control capture fields
    put_data(8'h65); put_ctrl(4'hF);
    chk("R3 hi addr", mem_addr[10:8], 3'h5); chk("R3 rw", mem_rw, 1);
    chk("R3 oe_n", mem_oe_n, 0);             chk("R3 ce_n", mem_ce_n, 0);
    put_ctrl(4'hB);

    // R2: quiet value with new data changes nothing
    sa = mem_addr;
    put_data(8'h9E); repeat (3) @(negedge clk);
    chk("R2 addr", mem_addr, sa); chk("R2 wdata", mem_wdata, 8'h00);

    // R4 + R6: low address capture, no recapture while held
    put_data(8'h81); put_ctrl(4'hA);
    chk("R4 lo", mem_addr[7:0], 8'h81);
    put_data(8'h18); repeat (2) @(negedge clk);
    chk("R6 held", mem_addr[7:0], 8'h81);
    put_ctrl(4'hB);

    // R5: data capture
    put_data(8'hE7); put_ctrl(4'h3);
    chk("R5 wdata", mem_wdata, 8'hE7);
    put_ctrl(4'hB);

    // R7: driver enable follows bit 6
    put_data(8'h20); put_ctrl(4'hF); put_ctrl(4'hB);
    chk("R7 write arm drv", mem_wdata_oe, 1);
    put_data(8'h70); put_ctrl(4'hF); put_ctrl(4'hB);
    chk("R7 read arm drv", mem_wdata_oe, 0);

    // R8 + R9: nibbles of 0xA5 at address 0x155 (high nibble has bit 3 set)
    put_data(8'h61); put_ctrl(4'hF); put_ctrl(4'hB);
    put_data(8'h55); put_ctrl(4'hA); put_ctrl(4'hB);
    chk("R8 low nibble", host_view(), 4'h5);
    put_ctrl(4'h9);
    chk("R8 high nibble", host_view(), 4'hA);
    chk("R9 pin pre-inverted", host_status[3], 1'b0);
    put_ctrl(4'hB);

    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule